// File: doc/BRIEF.md
# Multi-Cycle Functional Unit Issue Control

This block decides, cycle by cycle, whether the instruction held in decode may be sent to the execute stage. The execute stage has four units, each with its own fixed latency:

| Unit | Latency | Accepts a new operation |
|------|---------|-------------------------|
| Integer ALU | 1 cycle | every cycle |
| FP adder | 4 cycles | every cycle |
| FP/integer multiplier | 7 cycles | every cycle |
| Divider | 25 cycles | not pipelined |

Each offered instruction carries a unit code, a destination register and two source registers. The block either issues the instruction or holds it in decode. Issue is strictly in order, so a held instruction blocks everything behind it.

The block follows every issued instruction until it reaches the memory stage, where its result arrives. It stalls an instruction for any of three reasons:
- a source register is not yet forwardable;
- the divider is still busy;
- its arrival cycle is already taken by an older instruction.

It also tells the writeback path whether an arriving result may update the register file. That is refused when a younger instruction to the same register has already been issued. The arithmetic itself is outside the block and is modelled as a set of fixed delays.

Top module: `issue_control`

## Requirements
- R1: After reset no result is pending: `wb_valid` and `wb_write` are 0, and with `in_valid` low `issue_o` and `stall_o` are 0.
- R2: Unit codes are 0 integer, 1 FP adder, 2 multiplier, 3 divider. An instruction issued in cycle c appears with `wb_valid`=1 and its destination on `wb_dst` in cycle c+1, c+4, c+7 or c+25 respectively.
- R3: The integer unit, adder and multiplier accept one new instruction every cycle: independent instructions offered back to back issue in consecutive cycles.
- R4: A divide cannot issue until 25 cycles after the previous divide issued. A divide offered earlier is stalled.
- R5: At most one instruction arrives at the memory stage per cycle. An instruction whose arrival cycle is already taken stalls in decode until its arrival cycle is free.
- R6: An instruction that reads a register with a pending write stalls until the latest writer of that register is in its arrival cycle. It issues in that same cycle, through forwarding.
- R7: When a younger instruction to the same destination issued before an older one arrives, the older one arrives with `wb_write`=0 and the younger one with `wb_write`=1.
- R8: `issue_o` = `in_valid` and not stalled; `stall_o` = `in_valid` and a hazard. A stalled instruction is not issued, and nothing behind it issues.
- R9: An arriving instruction whose destination has no younger writer in flight has `wb_write`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode holds an instruction |
| in_unit | input | 2 | Unit code: 0 integer, 1 adder, 2 multiplier, 3 divider |
| in_dst | input | 5 | Destination register |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| issue_o | output | 1 | Instruction issues this cycle |
| stall_o | output | 1 | Instruction is held in decode this cycle |
| wb_valid | output | 1 | An issued instruction arrives this cycle |
| wb_dst | output | 5 | Destination of the arriving instruction |
| wb_write | output | 1 | The arriving result may update the register file |

## Verification
The bench sweeps every ordered pair of unit codes, once with the second instruction reading the first one's result and once independent. It checks that the issue gap equals the producer's latency in the dependent case and one cycle otherwise, or 25 cycles for two divides. A design that stalled one cycle too long would fail here, as would one that ignored forwarding, or one that let a divide in early.

A directed sequence (multiply, two integer ops, then an add) makes the add's arrival collide with the multiply's. A design that dropped the collision check would show two arrivals in one cycle and lose one.

A write-after-write case puts a multiply and a younger integer op on the same register. A design without latest-writer tracking would let the stale multiply result overwrite the newer value.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;
endpackage

// File: rtl/issue_slot_line.sv
// One entry per future cycle; entry 0 is the instruction arriving now.
module issue_slot_line #(
  parameter int DEPTH = 25,
  parameter int REG_W = 5,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [REG_W-1:0] ins_dst,
  input  logic [TAG_W-1:0] ins_tag,
  output logic [DEPTH:0]   occ,
  output logic             head_v,
  output logic [REG_W-1:0] head_dst,
  output logic [TAG_W-1:0] head_tag
);
  logic             v_q   [DEPTH];
  logic             v_d   [DEPTH];
  logic [REG_W-1:0] dst_q [DEPTH];
  logic [REG_W-1:0] dst_d [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      if (j < DEPTH - 1) begin
        v_d[j]   = v_q[j+1];
        dst_d[j] = dst_q[j+1];
        tag_d[j] = tag_q[j+1];
      end else begin
        v_d[j]   = 1'b0;
        dst_d[j] = dst_q[j];
        tag_d[j] = tag_q[j];
      end
    end
    if (ins_en) begin
      v_d[ins_idx]   = 1'b1;
      dst_d[ins_idx] = ins_dst;
      tag_d[ins_idx] = ins_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) v_q[j] <= 1'b0;
    end else begin
      for (int j = 0; j < DEPTH; j++) v_q[j] <= v_d[j];
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      dst_q[j] <= dst_d[j];
      tag_q[j] <= tag_d[j];
    end
  end

  always_comb begin
    occ[DEPTH] = 1'b0;
    for (int j = 0; j < DEPTH; j++) occ[j] = v_q[j];
  end

  assign head_v   = v_q[0];
  assign head_dst = dst_q[0];
  assign head_tag = tag_q[0];

  // R5
  slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !occ[32'(ins_idx) + 1]);
endmodule

// File: rtl/issue_reg_tags.sv
// Per-register latest-writer tag and pending flag.
module issue_reg_tags #(
  parameter int NREG  = 32,
  parameter int TAG_W = 6,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             head_v,
  input  logic [REG_W-1:0] head_dst,
  input  logic [TAG_W-1:0] head_tag,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             raw_a,
  output logic             raw_b,
  output logic             head_owner
);
  logic             pv_q [NREG];
  logic             pv_d [NREG];
  logic [TAG_W-1:0] pt_q [NREG];
  logic [TAG_W-1:0] pt_d [NREG];

  assign head_owner = head_v && pv_q[head_dst] && (pt_q[head_dst] == head_tag);
  assign raw_a = pv_q[src_a] &&
                 !(head_v && head_dst == src_a && head_tag == pt_q[src_a]);
  assign raw_b = pv_q[src_b] &&
                 !(head_v && head_dst == src_b && head_tag == pt_q[src_b]);

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      pv_d[r] = pv_q[r];
      pt_d[r] = pt_q[r];
    end
    if (head_owner) pv_d[head_dst] = 1'b0;
    if (set_en) begin
      pv_d[set_reg] = 1'b1;
      pt_d[set_reg] = set_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) pv_q[r] <= 1'b0;
    end else begin
      for (int r = 0; r < NREG; r++) pv_q[r] <= pv_d[r];
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) pt_q[r] <= pt_d[r];
  end

  // R7
  tag_latest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (pv_q[$past(set_reg)] && pt_q[$past(set_reg)] == $past(set_tag)));
  // R6
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (!raw_a && !raw_b));
endmodule

// File: rtl/issue_div_gap.sv
// Busy window of a non-pipelined unit.
module issue_div_gap #(
  parameter int GAP = 25,
  localparam int CNT_W = $clog2(GAP)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)               cnt_d = CNT_W'(GAP - 1);
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R4
  div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0));
endmodule

// File: rtl/issue_control.sv
module issue_control #(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 25,
  localparam int REG_W  = $clog2(NREG),
  localparam int DEPTH  = LAT_DIV,
  localparam int TAG_W  = $clog2(DEPTH) + 1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LAT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_unit,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  output logic             issue_o,
  output logic             stall_o,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_dst,
  output logic             wb_write
);
  import issue_pkg::*;

  unit_e            unit;
  logic [LAT_W-1:0] lat;
  logic [DEPTH:0]   occ;
  logic             head_v, head_owner, raw_a, raw_b, div_busy, is_div, slot_hit;
  logic [REG_W-1:0] head_dst;
  logic [TAG_W-1:0] head_tag;
  logic [TAG_W-1:0] tag_q, tag_d;

  assign unit = unit_e'(in_unit);

  always_comb begin
    case (unit)
      UNIT_INT: lat = LAT_W'(LAT_INT);
      UNIT_ADD: lat = LAT_W'(LAT_ADD);
      UNIT_MUL: lat = LAT_W'(LAT_MUL);
      default:  lat = LAT_W'(LAT_DIV);
    endcase
  end

  assign is_div   = (unit == UNIT_DIV);
  assign slot_hit = occ[lat];
  assign stall_o  = in_valid && (raw_a || raw_b || (is_div && div_busy) || slot_hit);
  assign issue_o  = in_valid && !stall_o;

  always_comb begin
    tag_d = tag_q;
    if (issue_o) tag_d = tag_q + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  issue_slot_line #(.DEPTH(DEPTH), .REG_W(REG_W), .TAG_W(TAG_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .ins_en(issue_o),
    .ins_idx(IDX_W'(lat - LAT_W'(1))), .ins_dst(in_dst), .ins_tag(tag_q),
    .occ(occ), .head_v(head_v), .head_dst(head_dst), .head_tag(head_tag));

  issue_reg_tags #(.NREG(NREG), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .set_en(issue_o), .set_reg(in_dst), .set_tag(tag_q),
    .head_v(head_v), .head_dst(head_dst), .head_tag(head_tag),
    .src_a(in_src_a), .src_b(in_src_b), .raw_a(raw_a), .raw_b(raw_b),
    .head_owner(head_owner));

  issue_div_gap #(.GAP(LAT_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .start(issue_o && is_div), .busy(div_busy));

  assign wb_valid = head_v;
  assign wb_dst   = head_dst;
  assign wb_write = head_owner;

  // R9
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_write |-> wb_valid);

  generate
    if (LAT_INT == 1) begin : g_int_lat
      // R2
      int_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && unit == UNIT_INT) |=> (wb_valid && wb_dst == $past(in_dst)));
    end
  endgenerate
endmodule

// File: tb/tb_issue_control.sv
module tb_issue_control;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_unit;
  logic [4:0] in_dst, in_src_a, in_src_b;
  logic       issue_o, stall_o, wb_valid, wb_write;
  logic [4:0] wb_dst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seq    = 0;
  bit done   = 0;

  bit   exp_v   [64];
  int   exp_seq [64];
  logic [4:0] exp_dst [64];
  int   last_seq [32];

  issue_control dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .issue_o(issue_o), .stall_o(stall_o), .wb_valid(wb_valid),
    .wb_dst(wb_dst), .wb_write(wb_write));

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lat_of(input int u);
    case (u)
      0: return 1;
      1: return 4;
      2: return 7;
      default: return 25;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp_val, input string what);
    checks++;
    if (act != exp_val) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_val);
    end
  endtask

  // Arrival monitor: R2 timing, R5 single arrival, R7/R9 write permission.
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1) begin
      int i;
      i = cyc % 64;
      if (exp_v[i] || wb_valid) begin
        bit ew;
        ew = exp_v[i] && (last_seq[exp_dst[i]] == exp_seq[i]);
        checks++;
        if (wb_valid !== exp_v[i] || (exp_v[i] && (wb_dst !== exp_dst[i] || wb_write !== ew))) begin
          fails++;
          $display("FAIL R2/R7/R9 arrival cycle %0d: actual v=%0b d=%0d w=%0b expected v=%0b d=%0d w=%0b",
                   cyc, wb_valid, wb_dst, wb_write, exp_v[i], exp_dst[i], ew);
        end
        exp_v[i] = 0;
      end
      if (issue_o) begin
        int k;
        k = (cyc + lat_of(int'(in_unit))) % 64;
        seq++;
        last_seq[in_dst] = seq;
        if (exp_v[k]) begin
          fails++;
          $display("FAIL R5 two arrivals in cycle %0d: actual 2 expected 1", cyc + lat_of(int'(in_unit)));
        end
        exp_v[k] = 1; exp_dst[k] = in_dst; exp_seq[k] = seq;
      end
    end
  end

  task automatic offer(input int u, input int d, input int a, input int b, output int c);
    in_valid = 1'b1; in_unit = 2'(u); in_dst = 5'(d); in_src_a = 5'(a); in_src_b = 5'(b);
    #1;
    while (issue_o !== 1'b1) begin
      @(negedge clk); #1;
    end
    c = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, c1, c2, c3;
    for (int i = 0; i < 64; i++) exp_v[i] = 0;
    for (int r = 0; r < 32; r++) last_seq[r] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_unit = '0; in_dst = '0; in_src_a = '0; in_src_b = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    #1;
    // R1 reset state
    check("R1", int'(wb_valid), 0, "wb_valid after reset");
    check("R1", int'(wb_write), 0, "wb_write after reset");
    check("R1", int'(issue_o), 0, "issue_o idle");
    check("R1", int'(stall_o), 0, "stall_o idle");
    @(negedge clk);

    // R6 / R2 / R4: sweep over all unit pairs, dependent and independent
    for (int u1 = 0; u1 < 4; u1++) begin
      for (int u2 = 0; u2 < 4; u2++) begin
        for (int dep = 0; dep < 2; dep++) begin
          int exp_gap;
          offer(u1, 1, 10, 11, c0);
          if (dep == 1) offer(u2, 2, 1, 1, c1);
          else          offer(u2, 2, 12, 13, c1);
          if (dep == 1)                exp_gap = lat_of(u1);
          else if (u1 == 3 && u2 == 3) exp_gap = 25;
          else if (lat_of(u1) == 1 + lat_of(u2)) exp_gap = 2;
          else                         exp_gap = 1;
          if (dep == 1) check("R6", c1 - c0, exp_gap, $sformatf("dependent gap u%0d->u%0d", u1, u2));
          else if (u1 == 3 && u2 == 3) check("R4", c1 - c0, exp_gap, "divide gap");
          else check("R3", c1 - c0, exp_gap, $sformatf("independent gap u%0d->u%0d", u1, u2));
          idle(30);
        end
      end
    end

    // R3: back-to-back adds and multiplies
    offer(1, 3, 20, 21, c0);
    offer(1, 4, 20, 21, c1);
    offer(2, 5, 20, 21, c2);
    offer(2, 6, 20, 21, c3);
    check("R3", c1 - c0, 1, "add after add");
    check("R3", c3 - c2, 1, "mul after mul");
    idle(30);

    // R5: mul, int, int, then add whose arrival would collide with the mul
    offer(2, 7, 20, 21, c0);
    offer(0, 8, 20, 21, c1);
    offer(0, 9, 20, 21, c2);
    offer(1, 14, 20, 21, c3);
    check("R5", c3 - c0, 4, "add delayed past arrival collision");
    idle(30);

    // R7 / R9: older mul overtaken by younger int on same register
    offer(2, 15, 20, 21, c0);
    offer(0, 15, 20, 21, c1);
    check("R8", c1 - c0, 1, "younger write not stalled by WAW");
    idle(2);
    #1;
    check("R9", int'(stall_o), 0, "no pending after younger write done");
    offer(0, 16, 15, 15, c2);
    check("R6", c2 - c1, 3, "reader of r15 issues once younger write retired");
    idle(30);

    // R8: stalled divide blocks a following integer op
    offer(3, 17, 20, 21, c0);
    in_valid = 1'b1; in_unit = 2'd3; in_dst = 5'd18; in_src_a = 5'd20; in_src_b = 5'd21;
    #1;
    check("R8", int'(stall_o), 1, "second divide stalls");
    check("R8", int'(issue_o), 0, "second divide not issued");
    #1;
    in_valid = 1'b0;
    offer(3, 18, 20, 21, c1);
    offer(0, 19, 20, 21, c2);
    check("R4", c1 - c0, 25, "divide gap directed");
    check("R8", c2 - c1, 1, "int follows divide in order");
    idle(40);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule